// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block adds or subtracts two 64-bit words that are treated as a group of independent packed integer lanes. The lane width is chosen per operation: 8, 16 or 32 bits, or the whole word as one lane. The carry chain is cut at every lane edge, so no lane's result depends on any other lane. Each lane then either keeps its wrapped result or is clamped to the limit of its range. Clamping can be signed or unsigned.

An operation is issued by raising the valid strobe for one cycle with both operands and the three control fields. The packed result and a mask with one bit per lane appear one clock later. A mask bit is set for each lane that was clamped. Subtraction adds the inverted second operand, and a carry of one is injected separately at the bottom of every lane.

Top module: `simd_packed_adder`

## Requirements
- R1: `in_size` selects the lane width: 2'b00 gives 8-bit lanes (8 lanes), 2'b01 gives 16-bit lanes (4 lanes), 2'b10 gives 32-bit lanes (2 lanes), and 2'b11 gives one 64-bit lane. Lane i occupies bits [w*i+w-1 : w*i], and no carry passes from one lane into the next.
- R2: With `in_sub` = 0 each lane computes a + b. With `in_sub` = 1 each lane computes a - b.
- R3: With `in_mode` = 2'b00 (wrap), each lane's result is the exact result modulo 2^w, and every bit of `out_sat` is 0.
- R4: With `in_mode` = 2'b01 (signed saturation), a lane whose signed result lies outside the range of a w-bit signed integer is replaced by the most-positive value (0 followed by ones) or the most-negative value (1 followed by zeros), whichever is nearer the exact result.
- R5: With `in_mode` = 2'b10 (unsigned saturation), an addition that exceeds 2^w-1 yields all ones, and a subtraction with b > a yields zero.
- R6: `in_mode` = 2'b11 behaves exactly as wrap mode.
- R7: `out_sat` bit i is 1 exactly when lane i was clamped. Bits at or above the lane count read 0.
- R8: `out_vld` is high for exactly the one cycle after each cycle in which `in_vld` is high. `out_res` and `out_sat` change only on such a cycle and hold their values otherwise.
- R9: While `rst_n` is low, `out_vld`, `out_res` and `out_sat` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operation strobe |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| in_size | input | 2 | Lane width code |
| in_mode | input | 2 | Wrap / signed saturate / unsigned saturate |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_vld | output | 1 | Result strobe |
| out_res | output | 64 | Packed result |
| out_sat | output | 8 | Per-lane clamp mask |

## Verification
The assertions assume that the control fields and operands are stable and meaningful in every cycle in which `in_vld` is high. They also assume that `in_vld` is low while reset is held, because the output-strobe properties compare against the strobe one cycle earlier. The bench drives every input on the falling clock edge and holds `in_vld` low throughout reset. It raises `in_vld` only together with a complete operation. The hold checks drive different operands with the strobe low to show that the outputs do not move.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int WORD_W = 64;
  localparam int UNIT_W = 8;
  localparam int UNITS  = WORD_W / UNIT_W;
  localparam int SIZE_W = $clog2(UNITS) + 1;

  typedef enum logic [1:0] {
    MD_WRAP = 2'b00,
    MD_SSAT = 2'b01,
    MD_USAT = 2'b10,
    MD_RSVD = 2'b11
  } sat_mode_e;

  // number of basic units spanned by one lane for a given size code
  function automatic int unsigned lane_span(input logic [1:0] sz, input int unsigned units);
    int unsigned s;
    s = 1 << sz;
    if (s > units) s = units;
    return s;
  endfunction

  // index of the top unit of the lane that holds unit u
  function automatic int unsigned lane_top(input int unsigned u, input int unsigned span);
    return u | (span - 1);
  endfunction
endpackage

// File: rtl/simd_lane_geom.sv
module simd_lane_geom #(
  parameter int UNITS = 8
) (
  input  logic [1:0]       size,
  output logic [UNITS-1:0] lane_start,
  output logic [UNITS-1:0] lane_end
);
  import simd_add_pkg::*;

  int unsigned span;
  assign span = lane_span(size, UNITS);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign lane_start[u] = ((u & (span - 1)) == 0);
    assign lane_end[u]   = ((u & (span - 1)) == span - 1);
  end
endmodule

// File: rtl/simd_carry_chain.sv
module simd_carry_chain #(
  parameter int UNIT_W = 8,
  parameter int UNITS  = 8,
  localparam int WORD_W = UNIT_W * UNITS
) (
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              sub,
  input  logic [UNITS-1:0]  lane_start,
  output logic [WORD_W-1:0] sum,
  output logic [UNITS-1:0]  carry_out,
  output logic [UNITS-1:0]  sgn_ovf
);
  logic [WORD_W-1:0] opb_x;
  logic [UNITS-1:0]  carry_in;

  assign opb_x = sub ? ~opb : opb;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [UNIT_W:0]   part;
    logic [UNIT_W-1:0] ua, ub;
    assign ua = opa[u*UNIT_W +: UNIT_W];
    assign ub = opb_x[u*UNIT_W +: UNIT_W];
    if (u == 0) begin : g_first
      assign carry_in[u] = sub;
    end else begin : g_rest
      assign carry_in[u] = lane_start[u] ? sub : carry_out[u-1];
    end
    assign part = {1'b0, ua} + {1'b0, ub} + {{UNIT_W{1'b0}}, carry_in[u]};
    assign sum[u*UNIT_W +: UNIT_W] = part[UNIT_W-1:0];
    assign carry_out[u] = part[UNIT_W];
    assign sgn_ovf[u] = (ua[UNIT_W-1] == ub[UNIT_W-1]) &&
                        (part[UNIT_W-1] != ua[UNIT_W-1]);
  end
endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
  parameter int UNIT_W = 8,
  parameter int UNITS  = 8,
  localparam int WORD_W = UNIT_W * UNITS
) (
  input  logic [WORD_W-1:0] sum,
  input  logic [WORD_W-1:0] opa,
  input  logic [UNITS-1:0]  carry_out,
  input  logic [UNITS-1:0]  sgn_ovf,
  input  logic              sub,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] res,
  output logic [UNITS-1:0]  unit_hit
);
  import simd_add_pkg::*;

  int unsigned span;
  assign span = lane_span(size, UNITS);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    int unsigned top;
    logic s_hit, u_hit, a_neg;
    logic [UNIT_W-1:0] ext;

    assign top   = lane_top(u, span);
    assign a_neg = opa[top*UNIT_W + UNIT_W - 1];
    assign s_hit = (mode == MD_SSAT) && sgn_ovf[top];
    assign u_hit = (mode == MD_USAT) && (carry_out[top] != sub);
    assign unit_hit[u] = s_hit | u_hit;

    always_comb begin
      ext = sum[u*UNIT_W +: UNIT_W];
      if (s_hit) begin
        ext = a_neg ? '0 : '1;
        if (top == u) ext[UNIT_W-1] = a_neg;
      end else if (u_hit) begin
        ext = sub ? '0 : '1;
      end
    end
    assign res[u*UNIT_W +: UNIT_W] = ext;
  end
endmodule

// File: rtl/simd_packed_adder.sv
module simd_packed_adder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic        in_sub,
  input  logic [1:0]  in_size,
  input  logic [1:0]  in_mode,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_vld,
  output logic [63:0] out_res,
  output logic [7:0]  out_sat
);
  import simd_add_pkg::*;

  logic [UNITS-1:0]  lane_start, lane_end;
  logic [WORD_W-1:0] raw_sum, clamped;
  logic [UNITS-1:0]  carry_out, sgn_ovf, unit_hit;
  logic [UNITS-1:0]  lane_flags;
  int unsigned       span;

  simd_lane_geom #(.UNITS(UNITS)) u_geom (
    .size(in_size), .lane_start(lane_start), .lane_end(lane_end)
  );

  simd_carry_chain #(.UNIT_W(UNIT_W), .UNITS(UNITS)) u_chain (
    .opa(in_a), .opb(in_b), .sub(in_sub), .lane_start(lane_start),
    .sum(raw_sum), .carry_out(carry_out), .sgn_ovf(sgn_ovf)
  );

  simd_lane_clamp #(.UNIT_W(UNIT_W), .UNITS(UNITS)) u_clamp (
    .sum(raw_sum), .opa(in_a), .carry_out(carry_out), .sgn_ovf(sgn_ovf),
    .sub(in_sub), .mode(in_mode), .size(in_size),
    .res(clamped), .unit_hit(unit_hit)
  );

  assign span = lane_span(in_size, UNITS);

  // gather one flag per lane, taken at the lane's top unit
  always_comb begin
    lane_flags = '0;
    for (int i = 0; i < UNITS; i++) begin
      if (i * span < UNITS) lane_flags[i] = unit_hit[i*span + span - 1] & lane_end[i*span + span - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_sat <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res <= clamped;
        out_sat <= lane_flags;
      end
    end
  end
endmodule

// File: rtl/simd_packed_adder_chk.sv
module simd_packed_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic        in_sub,
  input logic [1:0]  in_size,
  input logic [1:0]  in_mode,
  input logic [63:0] in_a,
  input logic [63:0] in_b,
  input logic        out_vld,
  input logic [63:0] out_res,
  input logic [7:0]  out_sat
);
  logic [64:0] wide_sum;
  assign wide_sum = {1'b0, in_a} + {1'b0, in_b};

  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_res) && $stable(out_sat)));
  assert_wrap_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (in_mode == 2'b00 || in_mode == 2'b11)) |=> (out_sat == 8'h00));
  assert_wide_upper_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 2'b11) |=> (out_sat[7:1] == 7'd0));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_size == 2'b11 && in_mode == 2'b10 && !in_sub && wide_sum[64])
    |=> (out_res == 64'hFFFF_FFFF_FFFF_FFFF && out_sat[0]));
endmodule

bind simd_packed_adder simd_packed_adder_chk u_chk (.*);

// File: tb/test_simd_packed_adder.sv
`timescale 1ns/1ps
module test_simd_packed_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0, in_sub = 1'b0;
  logic [1:0]  in_size = 2'd0, in_mode = 2'd0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_vld;
  logic [63:0] out_res;
  logic [7:0]  out_sat;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  simd_packed_adder i_simd_packed_adder (.*);

  // stimulus: {sub, size, mode, a, b}
  localparam logic [132:0] VEC [16] = '{
    {1'b0, 2'd0, 2'd0, 64'h7F80_FF01_1234_5678, 64'h0180_0101_EDCC_A988},
    {1'b1, 2'd0, 2'd0, 64'h0001_0203_0405_0607, 64'h0706_0504_0302_0100},
    {1'b0, 2'd0, 2'd1, 64'h7F80_7F80_1020_3040, 64'h0180_7FFF_7070_D0C0},
    {1'b1, 2'd0, 2'd1, 64'h807F_8000_7F00_0180, 64'h01FF_7F01_8001_0201},
    {1'b0, 2'd0, 2'd2, 64'hFF01_80F0_0102_C0C0, 64'h01FF_8010_FEFE_4041},
    {1'b1, 2'd0, 2'd2, 64'h0001_0510_FF00_8080, 64'h0100_0611_00FF_7F81},
    {1'b0, 2'd1, 2'd1, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_C000},
    {1'b1, 2'd1, 2'd2, 64'h0000_FFFF_1234_8000, 64'h0001_FFFF_1235_7FFF},
    {1'b0, 2'd1, 2'd0, 64'hFFFF_FFFF_0001_8000, 64'h0001_0001_FFFF_8000},
    {1'b0, 2'd2, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF},
    {1'b1, 2'd2, 2'd2, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_0000_0001},
    {1'b1, 2'd2, 2'd0, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001},
    {1'b0, 2'd3, 2'd1, 64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0100},
    {1'b1, 2'd3, 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {1'b1, 2'd3, 2'd2, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004},
    {1'b0, 2'd0, 2'd3, 64'h7F7F_FFFF_8080_0101, 64'h0101_0101_8080_FFFF}
  };

  // independent lane-by-lane model
  function automatic void model(input logic sub, input logic [1:0] sz, input logic [1:0] md,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic [7:0] f);
    int w, n;
    logic [65:0] mask, ua, ub, raw, val;
    logic signed [66:0] sa, sb, sr, smax, smin;
    w = 8 << sz; n = 64 / w;
    mask = (66'd1 << w) - 66'd1;
    r = '0; f = '0;
    for (int l = 0; l < n; l++) begin
      ua = ({2'b0, a} >> (l*w)) & mask;
      ub = ({2'b0, b} >> (l*w)) & mask;
      raw = sub ? ua - ub : ua + ub;
      val = raw & mask;
      if (md == 2'b10) begin
        if (!sub && raw > mask) begin val = mask; f[l] = 1'b1; end
        if (sub && ua < ub) begin val = '0; f[l] = 1'b1; end
      end else if (md == 2'b01) begin
        sa = ua[w-1] ? $signed({1'b0, ua}) - (67'sd1 <<< w) : $signed({1'b0, ua});
        sb = ub[w-1] ? $signed({1'b0, ub}) - (67'sd1 <<< w) : $signed({1'b0, ub});
        sr = sub ? sa - sb : sa + sb;
        smax = (67'sd1 <<< (w-1)) - 67'sd1;
        smin = -(67'sd1 <<< (w-1));
        if (sr > smax) begin val = smax[65:0]; f[l] = 1'b1; end
        if (sr < smin) begin val = smin[65:0] & mask; f[l] = 1'b1; end
      end
      r = r | (val[63:0] << (l*w));
    end
  endfunction

  task automatic check(input string tag, input logic [63:0] er, input logic [7:0] ef);
    n_vec++;
    if (out_res !== er || out_sat !== ef || out_vld !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: res=%h sat=%b vld=%b expected res=%h sat=%b vld=1",
               tag, out_res, out_sat, out_vld, er, ef);
    end
  endtask

  task automatic issue(input logic sub, input logic [1:0] sz, input logic [1:0] md,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_vld = 1'b1; in_sub = sub; in_size = sz; in_mode = md; in_a = a; in_b = b;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    logic [63:0] er, keep_r; logic [7:0] ef, keep_f;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_vld !== 1'b0 || out_res !== 64'd0 || out_sat !== 8'd0) begin
      n_bad++;
      $display("FAIL R9: vld=%b res=%h sat=%b expected 0/0/0", out_vld, out_res, out_sat);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      issue(VEC[i][132], VEC[i][131:130], VEC[i][129:128], VEC[i][127:64], VEC[i][63:0]);
      model(VEC[i][132], VEC[i][131:130], VEC[i][129:128], VEC[i][127:64], VEC[i][63:0], er, ef);
      check($sformatf("R1/R2/R4/R5 vector %0d", i), er, ef);
    end

    // R1: carry stops at a byte edge, but runs through in the 64-bit lane
    issue(1'b0, 2'd0, 2'd0, 64'h0000_0000_0000_00FF, 64'h1);
    check("R1 byte boundary", 64'h0, 8'h00);
    issue(1'b0, 2'd3, 2'd0, 64'h0000_0000_0000_00FF, 64'h1);
    check("R1 single lane", 64'h100, 8'h00);
    // R2 subtraction across 16-bit lanes
    issue(1'b1, 2'd1, 2'd0, 64'h0010_0000_0005_0003, 64'h0001_0001_0002_0004);
    check("R2 sub wrap", 64'h000F_FFFF_0003_FFFF, 8'h00);
    // R4 signed clamps
    issue(1'b0, 2'd0, 2'd1, 64'h7F, 64'h01);
    check("R4 byte max", 64'h7F, 8'h01);
    issue(1'b1, 2'd2, 2'd1, 64'h8000_0000, 64'h1);
    check("R4 word min", 64'h8000_0000, 8'h01);
    // R5 unsigned clamps
    issue(1'b1, 2'd1, 2'd2, 64'h0001_0005, 64'h0002_0003);
    check("R5 underflow", 64'h0000_0002, 8'h02);
    issue(1'b0, 2'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    check("R5 R7 full width", 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
    // R6 reserved mode wraps
    issue(1'b0, 2'd0, 2'd3, 64'h7F, 64'h01);
    check("R6 reserved mode", 64'h80, 8'h00);
    // R3 wrap flags clear despite overflow
    issue(1'b0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3 wrap", 64'hFEFE_FEFE_FEFE_FEFE, 8'h00);
    // R7 all eight flags in byte mode
    issue(1'b0, 2'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    check("R7 eight flags", 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);

    // R8: single-cycle strobe and hold with new inputs
    keep_r = out_res; keep_f = out_sat;
    in_a = 64'h1234; in_b = 64'h5678; in_mode = 2'b01; in_size = 2'd0;
    @(negedge clk);
    n_vec++;
    if (out_vld !== 1'b0 || out_res !== keep_r || out_sat !== keep_f) begin
      n_bad++;
      $display("FAIL R8: vld=%b res=%h sat=%b expected 0 %h %b", out_vld, out_res, out_sat, keep_r, keep_f);
    end

    // R9: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    n_vec++;
    if (out_vld !== 1'b0 || out_res !== 64'd0 || out_sat !== 8'd0) begin
      n_bad++;
      $display("FAIL R9: vld=%b res=%h sat=%b expected 0/0/0", out_vld, out_res, out_sat);
    end
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule